// File: doc/BRIEF.md
# Byte-fed CRC-16 engine

A small register-mapped engine that computes a 16-bit cyclic redundancy check over a stream of bytes handed to it by software. Each write to the feed register absorbs one byte in a single clock. A hardware counter records how many bytes have gone in since the engine was last cleared. The accumulated check value can be read back raw, in its finished form, and in its finished form with the two bytes swapped.

The arithmetic uses the CCITT polynomial x^16+x^12+x^5+1. Bits are taken least-significant first, which is the reflected constant 0x8408. The remainder starts at 0xFFFF and is ones-complemented on readout. With these choices, a clear followed by the bytes 0xCC, 0xF5, 0xF1, 0xA7 leaves a count of 4 and a finished value of 0x51DF. Software can run this sequence at power-up as a self-test.

Word address map (addr_i): 0 control, 1 feed, 2 raw remainder, 3 finished value byte-swapped, 4 finished value. Addresses 5 to 7 read as zero.

Top module: `crc16_eng`

## Requirements
- R1: A write to address 0 with bit 15 set returns the remainder to 0xFFFF and the byte count to 0 on the next clock edge.
- R2: A read of address 0 gives the byte count in bits 11:0 and zero in bits 15:12, so the clear bit always reads back 0.
- R3: A write to address 1 absorbs only bits 7:0 of the data, least-significant bit first, with reflected polynomial 0x8408. Bits 15:8 have no effect. The write also increments the byte count by one.
- R4: The byte count saturates at 4095 (0xFFF) and does not wrap, while bytes keep being absorbed into the remainder.
- R5: Address 2 reads the raw remainder. Address 4 reads its ones complement. Address 3 reads that complement with bits 7:0 and 15:8 exchanged. Addresses 5 to 7 read 0.
- R6: After a clear, feeding 0xCC, 0xF5, 0xF1, 0xA7 gives count 4, address 4 reads 0x51DF and address 2 reads 0xAE20.
- R7: A write to address 0 with bit 15 clear, and any write to addresses 2 to 7, leave the remainder and count unchanged.
- R8: A feed write takes effect at the next clock edge. Writes on consecutive cycles each absorb one byte.
- R9: While rst_ni is low, the count is 0 and the remainder is 0xFFFF, so address 4 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one access per cycle |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |

## Verification
The assertions run on every cycle and check four things:
- a clear write empties the counter and restores the start value;
- each feed write below saturation adds exactly one to the count;
- a saturated count stays put;
- idle cycles, and writes that should be ignored, leave the state untouched.

Only the bench scenarios can show that the arithmetic is right. These include the self-test vector, the masking of the upper data byte, the byte-swapped readout, and the remainder after thousands of back-to-back bytes past saturation. The bench compares these against an independent model.

// File: rtl/crc16_eng_pkg.sv
package crc16_eng_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_FEED = 3'd1,
    REG_RAW  = 3'd2,
    REG_SWAP = 3'd3,
    REG_FIN  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/crc16_step.sv
module crc16_step #(
  parameter int          DATA_W = 16,
  parameter int          BYTE_W = 8,
  parameter logic [15:0] POLY   = 16'h8408
) (
  input  logic [DATA_W-1:0] crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DATA_W-1:0] crc_o
);
  logic [DATA_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_i;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    logic fb;
    assign fb = stage[k][0] ^ byte_i[k];
    assign stage[k+1] = (stage[k] >> 1) ^ (fb ? POLY[DATA_W-1:0] : '0);
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/crc16_accum.sv
module crc16_accum #(
  parameter int          DATA_W = 16,
  parameter int          BYTE_W = 8,
  parameter logic [15:0] POLY   = 16'h8408,
  parameter logic [15:0] INIT   = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              feed_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] nxt;

  crc16_step #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .POLY(POLY)) u_step (
    .crc_i (acc_o),
    .byte_i(byte_i),
    .crc_o (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= INIT[DATA_W-1:0];
    else if (clr_i)  acc_o <= INIT[DATA_W-1:0];
    else if (feed_i) acc_o <= nxt;
  end
endmodule

// File: rtl/crc16_byte_cnt.sv
module crc16_byte_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (inc_i && cnt_o != CntMax)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/crc16_reg_decode.sv
module crc16_reg_decode
  import crc16_eng_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          CNT_W   = 12,
  parameter int          CLR_BIT = 15,
  parameter logic [15:0] XOROUT  = 16'hFFFF
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output logic              feed_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HalfW = DATA_W / 2;

  logic [DATA_W-1:0] fin;

  assign clr_o  = we_i && (addr_i == REG_CTRL) && wdata_i[CLR_BIT];
  assign feed_o = we_i && (addr_i == REG_FEED);
  assign fin    = acc_i ^ XOROUT[DATA_W-1:0];

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
      REG_RAW:  rdata_o = acc_i;
      REG_SWAP: rdata_o = {fin[HalfW-1:0], fin[DATA_W-1:HalfW]};
      REG_FIN:  rdata_o = fin;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/crc16_eng.sv
module crc16_eng
  import crc16_eng_pkg::*;
#(
  parameter int          DATA_W  = 16,
  parameter int          BYTE_W  = 8,
  parameter int          CNT_W   = 12,
  parameter int          CLR_BIT = 15,
  parameter logic [15:0] POLY    = 16'h8408,
  parameter logic [15:0] INIT    = 16'hFFFF,
  parameter logic [15:0] XOROUT  = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              clr, feed;
  logic [DATA_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;

  crc16_reg_decode #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CLR_BIT(CLR_BIT), .XOROUT(XOROUT)
  ) u_dec (
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .acc_i  (acc_q),
    .cnt_i  (cnt_q),
    .clr_o  (clr),
    .feed_o (feed),
    .rdata_o(rdata_o)
  );

  crc16_accum #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .POLY(POLY), .INIT(INIT)
  ) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .feed_i(feed),
    .byte_i(wdata_i[BYTE_W-1:0]),
    .acc_o (acc_q)
  );

  crc16_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (feed),
    .cnt_o (cnt_q)
  );
endmodule

// File: rtl/crc16_eng_chk.sv
module crc16_eng_chk #(
  parameter int          DATA_W = 16,
  parameter int          CNT_W  = 12,
  parameter logic [15:0] INIT   = 16'hFFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] acc,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  localparam logic [DATA_W-1:0] ClrMask = {1'b1, {(DATA_W-1){1'b0}}};

  // R1
  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0 && (wdata_i & ClrMask) != '0)
      |=> (cnt == '0 && acc == INIT[DATA_W-1:0]));

  // R3
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd1 && cnt != CntMax) |=> (cnt == $past(cnt) + 1'b1));

  // R4
  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CntMax && !(we_i && addr_i == 3'd0 && (wdata_i & ClrMask) != '0))
      |=> (cnt == CntMax));

  // R7
  a_r7_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ((addr_i == 3'd0 && wdata_i < ClrMask) || addr_i >= 3'd2))
      |=> ($stable(acc) && $stable(cnt)));

  // R8
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(acc) && $stable(cnt)));
endmodule

bind crc16_eng crc16_eng_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .INIT(INIT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .acc    (acc_q),
  .cnt    (cnt_q)
);

// File: tb/tb_crc16_eng.sv
module tb_crc16_eng;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  crc16_eng dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    logic [2:0]  a;
    logic [15:0] e;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_crc;
  int m_cnt;

  function automatic logic [15:0] model_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic feed(input logic [15:0] d);
    wr(3'd1, d);
    m_crc = model_step(m_crc, d[7:0]);
    if (m_cnt < 4095) m_cnt++;
  endtask

  task automatic clear();
    wr(3'd0, 16'h8000);
    m_crc = 16'hFFFF; m_cnt = 0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    it.a = a; it.e = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_model(input string tag);
    expect_rd(3'd0, 16'(m_cnt), tag);
    expect_rd(3'd2, m_crc, tag);
    expect_rd(3'd4, ~m_crc, tag);
  endtask

  // monitor: samples mid-cycle, away from the active edge
  always @(posedge clk_i) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (rdata_o !== it.e) begin
        n_bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rdata_o, it.e);
      end
    end
  end

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_crc = 16'hFFFF; m_cnt = 0;
    // R9: values while reset is held
    expect_rd(3'd0, 16'h0000, "R9 ctrl in reset");
    expect_rd(3'd2, 16'hFFFF, "R9 raw in reset");
    expect_rd(3'd4, 16'h0000, "R9 fin in reset");
    @(negedge clk_i); rst_ni = 1'b1;

    // R6 self-test vector
    clear();
    feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
    expect_rd(3'd0, 16'd4,   "R6 count");
    expect_rd(3'd4, 16'h51DF, "R6 final");
    expect_rd(3'd2, 16'hAE20, "R6 raw");
    expect_rd(3'd3, 16'hDF51, "R5 swapped");
    expect_rd(3'd5, 16'h0000, "R5 unmapped");
    expect_rd(3'd7, 16'h0000, "R5 unmapped");

    // R3: upper byte ignored
    clear();
    feed(16'hABCC); feed(16'h12F5); feed(16'hFFF1); feed(16'h80A7);
    expect_rd(3'd4, 16'h51DF, "R3 upper byte ignored");
    expect_rd(3'd0, 16'd4,   "R3 count");

    // R2: clear bit reads back zero
    expect_rd(3'd0, 16'd4, "R2 ctrl high bits zero");

    // R7: ignored writes
    wr(3'd0, 16'h7FFF);
    wr(3'd2, 16'h1234);
    wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'h0000);
    wr(3'd6, 16'h8000);
    expect_rd(3'd0, 16'd4,    "R7 count unchanged");
    expect_rd(3'd4, 16'h51DF, "R7 result unchanged");

    // R8: single write visible next cycle, then a varied pattern
    feed(16'h0055);
    expect_model("R8 single feed");
    for (int i = 0; i < 20; i++) feed(16'((i * 37 + 11) & 16'hFFFF));
    expect_model("R8 back-to-back");

    // R1: clear mid-stream
    clear();
    expect_rd(3'd0, 16'h0000, "R1 count cleared");
    expect_rd(3'd2, 16'hFFFF, "R1 raw restored");
    feed(16'h0000);
    expect_model("R1 zero byte after clear");

    // R4: saturation
    clear();
    for (int i = 0; i < 4100; i++) feed(16'(i * 13));
    expect_rd(3'd0, 16'h0FFF, "R4 saturated count");
    expect_model("R4 crc continues");
    feed(16'h00A5);
    expect_model("R4 still saturated");
    clear();
    expect_rd(3'd0, 16'h0000, "R1 clear from saturation");

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule